// File: doc/BRIEF.md
# PPS-Aligned Tick Counter

This block keeps a 64-bit tick count in the radio clock domain. It advances by one on every clock. Software reaches it through a 32-bit register bus inside a 48-byte window. A pulse-per-second (PPS) input is brought into the clock domain through a flop chain, and its rising edges are detected there. Every detected edge does two things: it copies the running count into a capture register, and it inverts a presence flag that firmware can watch.

To set the time, software first stages a 64-bit value through two write-only words. It then writes a command word. One command code loads the staged value at once. A second code arms the block so that the value is loaded on the next PPS rising edge, which lets several units step to a common time on the same second. A 64-bit period value is held for software to write and read back; the counter itself does not use it. Each 64-bit read-only quantity can be read without tearing: reading its low word also latches its high word, and the latched copy is what the high-word read returns.

Top module: `tick_timekeeper`

## Requirements
- R1: A synchronous reset clears the tick count, the PPS capture, the staged value, the period, the armed flag, the presence flag, both high-word latches and the read data to zero.
- R2: In any cycle without a load, the tick count increases by exactly one, carrying from the low 32 bits into the high 32 bits.
- R3: Writing 0x1 to the command word at offset 0x10 loads the staged value, formed from offset 0x0C (bits 63:32) and offset 0x08 (bits 31:0), into the tick count at that clock edge.
- R4: Writing 0x2 to offset 0x10 arms a load. The staged value enters the tick count on the clock edge where the next synchronized PPS rise is seen, and the armed state then clears, so later PPS rises do not reload.
- R5: A 0x1 command cancels a pending arm. A PPS rise after the immediate load does not reload the counter.
- R6: The PPS input passes through two synchronizer flops and then an edge detector. On each detected rise, the count held before that edge is stored in the capture register, which is read at 0x14 (low word) and 0x18 (high word).
- R7: Output `pps_flip` inverts once per PPS rising edge. It stays unchanged while PPS is held high or held low.
- R8: A read of offset 0x00 returns count bits 31:0 and latches count bits 63:32. A read of 0x04 returns that latched value. Offsets 0x14 and 0x18 pair the same way for the capture register, with their own latch.
- R9: The period is read-write, with bits 31:0 at offset 0x1C and bits 63:32 at offset 0x20.
- R10: Writes to offsets 0x00, 0x04, 0x14, 0x18 and unmapped offsets change nothing, and command values other than 0x1 and 0x2 have no effect. Reads of 0x08, 0x0C, 0x10 and unmapped offsets return zero.
- R11: Read data is registered. It takes its new value on the clock edge that samples `bus_rd`, and holds that value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Radio clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous PPS input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset within the 48-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pps_flip | output | 1 | Presence flag, inverted on each PPS rise |

## Verification
The bench works through the following corner cases:
- An immediate load of a value just below a 32-bit boundary. Sampled after the carry, this exposes a counter that drops the carry, and a high-word read that returns the live count instead of the latched copy.
- An armed load across two PPS pulses. This catches a design that loads on the arm write itself, and one that fails to clear the armed flag and reloads on the second second.
- An arm that is overridden by an immediate load and then followed by a PPS pulse. This catches a stale arm firing later.
- A PPS held high for many cycles. This catches level-sensitive toggling of the presence flag or repeated capture.
- Writes to read-only offsets, unmapped offsets and the command word with unknown codes. Any side effect of these writes shows up as a count, capture or period that departs from the reference.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int TICK_W = 64;
    localparam int WORD_W = 32;

    typedef logic [TICK_W-1:0] tick_t;
    typedef logic [WORD_W-1:0] word_t;

    // Byte offsets inside the register window
    localparam int OFF_NOW_LO = 'h00;
    localparam int OFF_NOW_HI = 'h04;
    localparam int OFF_EVT_LO = 'h08;
    localparam int OFF_EVT_HI = 'h0C;
    localparam int OFF_CMD    = 'h10;
    localparam int OFF_CAP_LO = 'h14;
    localparam int OFF_CAP_HI = 'h18;
    localparam int OFF_PER_LO = 'h1C;
    localparam int OFF_PER_HI = 'h20;

    localparam word_t CMD_LOAD_NOW = 32'h1;
    localparam word_t CMD_ARM_PPS  = 32'h2;

    typedef enum logic [3:0] {
        SEL_NOW_LO,
        SEL_NOW_HI,
        SEL_EVT_LO,
        SEL_EVT_HI,
        SEL_CMD,
        SEL_CAP_LO,
        SEL_CAP_HI,
        SEL_PER_LO,
        SEL_PER_HI,
        SEL_NONE
    } tk_sel_e;

    typedef struct packed {
        logic load_now;
        logic arm;
    } tk_cmd_t;

    function automatic tk_sel_e decode_sel(input int unsigned a);
        case (a)
            OFF_NOW_LO: return SEL_NOW_LO;
            OFF_NOW_HI: return SEL_NOW_HI;
            OFF_EVT_LO: return SEL_EVT_LO;
            OFF_EVT_HI: return SEL_EVT_HI;
            OFF_CMD:    return SEL_CMD;
            OFF_CAP_LO: return SEL_CAP_LO;
            OFF_CAP_HI: return SEL_CAP_HI;
            OFF_PER_LO: return SEL_PER_LO;
            OFF_PER_HI: return SEL_PER_HI;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic word_t lo_word(input tick_t v);
        return v[WORD_W-1:0];
    endfunction

    function automatic word_t hi_word(input tick_t v);
        return v[TICK_W-1:WORD_W];
    endfunction

endpackage

// File: rtl/tk_pps_sync.sv
module tk_pps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pps_in,
    output logic pps_rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= pps_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    assign pps_rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/tk_counter.sv
module tk_counter
    import tk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_now,
    input  logic  arm_req,
    input  logic  pps_rise,
    input  tick_t staged,
    output tick_t tick,
    output tick_t cap,
    output logic  armed,
    output logic  flip
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick  <= '0;
            cap   <= '0;
            armed <= 1'b0;
            flip  <= 1'b0;
        end else begin
            if (load_now) begin
                tick  <= staged;
                armed <= 1'b0;
            end else if (armed && pps_rise) begin
                tick  <= staged;
                armed <= arm_req;
            end else begin
                tick  <= tick + 1'b1;
                armed <= armed | arm_req;
            end
            if (pps_rise) begin
                cap  <= tick;
                flip <= ~flip;
            end
        end
    end

endmodule

// File: rtl/tk_regs.sv
module tk_regs
    import tk_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  tick_t             tick,
    input  tick_t             cap,
    output tick_t             staged,
    output tk_cmd_t           cmd,
    output word_t             rdata
);

    localparam int NPAIR = 2;

    tk_sel_e sel;
    tick_t   period_q;
    tick_t   ro_src  [NPAIR];
    word_t   hold_hi [NPAIR];

    always_comb sel = decode_sel(32'(addr));

    always_comb begin
        cmd.load_now = wr && (sel == SEL_CMD) && (wdata == CMD_LOAD_NOW);
        cmd.arm      = wr && (sel == SEL_CMD) && (wdata == CMD_ARM_PPS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged   <= '0;
            period_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_EVT_LO: staged[WORD_W-1:0]        <= wdata;
                SEL_EVT_HI: staged[TICK_W-1:WORD_W]   <= wdata;
                SEL_PER_LO: period_q[WORD_W-1:0]      <= wdata;
                SEL_PER_HI: period_q[TICK_W-1:WORD_W] <= wdata;
                default: ;
            endcase
        end
    end

    assign ro_src[0] = tick;
    assign ro_src[1] = cap;

    // High-word latch per read-only pair, captured on its low-word read
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        localparam tk_sel_e LO_SEL = (i == 0) ? SEL_NOW_LO : SEL_CAP_LO;
        always_ff @(posedge clk) begin
            if (rst)                      hold_hi[i] <= '0;
            else if (rd && sel == LO_SEL) hold_hi[i] <= hi_word(ro_src[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            case (sel)
                SEL_NOW_LO: rdata <= lo_word(tick);
                SEL_NOW_HI: rdata <= hold_hi[0];
                SEL_CAP_LO: rdata <= lo_word(cap);
                SEL_CAP_HI: rdata <= hold_hi[1];
                SEL_PER_LO: rdata <= lo_word(period_q);
                SEL_PER_HI: rdata <= hi_word(period_q);
                default:    rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/tick_timekeeper.sv
module tick_timekeeper
    import tk_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pps_in,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pps_flip
);

    logic    pps_rise;
    logic    load_now;
    logic    arm_req;
    logic    armed_q;
    tk_cmd_t cmd;
    tick_t   tick_q;
    tick_t   cap_q;
    tick_t   staged_q;

    tk_pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pps_in   (pps_in),
        .pps_rise (pps_rise)
    );

    tk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .tick   (tick_q),
        .cap    (cap_q),
        .staged (staged_q),
        .cmd    (cmd),
        .rdata  (bus_rdata)
    );

    assign load_now = cmd.load_now;
    assign arm_req  = cmd.arm;

    tk_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_now (load_now),
        .arm_req  (arm_req),
        .pps_rise (pps_rise),
        .staged   (staged_q),
        .tick     (tick_q),
        .cap      (cap_q),
        .armed    (armed_q),
        .flip     (pps_flip)
    );

endmodule

// File: rtl/tick_timekeeper_chk.sv
module tick_timekeeper_chk
    import tk_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  pps_rise,
    input logic  load_now,
    input logic  arm_req,
    input logic  armed,
    input logic  flip,
    input logic  bus_rd,
    input tick_t tick,
    input tick_t cap,
    input tick_t staged,
    input word_t rdata
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (tick == '0 && cap == '0 && !armed && !flip && rdata == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!load_now && !(armed && pps_rise)) |=> tick == $past(tick) + 64'd1);

    assert_load_now_R3: assert property (@(posedge clk) disable iff (rst)
        load_now |=> tick == $past(staged));

    assert_armed_load_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && pps_rise && !load_now && !arm_req) |=> (!armed && tick == $past(staged)));

    assert_cancel_arm_R5: assert property (@(posedge clk) disable iff (rst)
        load_now |=> !armed);

    assert_capture_R6: assert property (@(posedge clk) disable iff (rst)
        pps_rise |=> cap == $past(tick));

    assert_flip_edge_R7: assert property (@(posedge clk) disable iff (rst)
        pps_rise |=> flip != $past(flip));

    assert_flip_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !pps_rise |=> $stable(flip));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(rdata));

endmodule

bind tick_timekeeper tick_timekeeper_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pps_rise (pps_rise),
    .load_now (load_now),
    .arm_req  (arm_req),
    .armed    (armed_q),
    .flip     (pps_flip),
    .bus_rd   (bus_rd),
    .tick     (tick_q),
    .cap      (cap_q),
    .staged   (staged_q),
    .rdata    (bus_rdata)
);

// File: tb/tick_timekeeper_tb.sv
module tick_timekeeper_tb;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pps = 1'b0;
    logic          bwr = 1'b0;
    logic          brd = 1'b0;
    logic [AW-1:0] badr = '0;
    logic [31:0]   bwd = '0;
    logic [31:0]   brdata;
    logic          flip;

    always #2 clk = ~clk;

    tick_timekeeper #(.ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .pps_in    (pps),
        .bus_wr    (bwr),
        .bus_rd    (brd),
        .bus_addr  (badr),
        .bus_wdata (bwd),
        .bus_rdata (brdata),
        .pps_flip  (flip)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference model, updated on each rising edge
    logic [63:0] m_cnt, m_cap, m_stg, m_per;
    logic [31:0] m_rd, m_hn, m_hc;
    logic        m_arm, m_flip, m_s1, m_s2, m_s3;

    always @(posedge clk) begin : model
        logic        rise, ld, arm;
        logic [63:0] c0;
        if (rst) begin
            m_cnt = 0; m_cap = 0; m_stg = 0; m_per = 0;
            m_rd = 0; m_hn = 0; m_hc = 0;
            m_arm = 0; m_flip = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            rise = m_s2 && !m_s3;
            c0   = m_cnt;
            ld   = bwr && badr == 6'h10 && bwd == 32'h1;
            arm  = bwr && badr == 6'h10 && bwd == 32'h2;
            if (brd) begin
                case (badr)
                    6'h00: begin m_rd = c0[31:0]; m_hn = c0[63:32]; end
                    6'h04: m_rd = m_hn;
                    6'h14: begin m_rd = m_cap[31:0]; m_hc = m_cap[63:32]; end
                    6'h18: m_rd = m_hc;
                    6'h1C: m_rd = m_per[31:0];
                    6'h20: m_rd = m_per[63:32];
                    default: m_rd = 0;
                endcase
            end
            if (ld) begin
                m_cnt = m_stg; m_arm = 0;
            end else if (m_arm && rise) begin
                m_cnt = m_stg; m_arm = arm;
            end else begin
                m_cnt = c0 + 1; m_arm = m_arm | arm;
            end
            if (rise) begin
                m_cap  = c0;
                m_flip = !m_flip;
            end
            if (bwr) begin
                case (badr)
                    6'h08: m_stg[31:0]  = bwd;
                    6'h0C: m_stg[63:32] = bwd;
                    6'h1C: m_per[31:0]  = bwd;
                    6'h20: m_per[63:32] = bwd;
                    default: ;
                endcase
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pps;
        end
    end

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(cur_req, brdata, m_rd);
            chk(cur_req, flip, m_flip);
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bwr = 1'b1; badr = a[AW-1:0]; bwd = d;
        @(negedge clk);
        bwr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        brd = 1'b1; badr = a[AW-1:0];
        @(negedge clk);
        brd = 1'b0;
        d = brdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        @(negedge clk);
        pps = 1'b1;
        repeat (hi) @(negedge clk);
        pps = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen at the ports
        cur_req = "R1";
        chk("R1", brdata, 32'h0);
        chk("R1", flip, 1'b0);
        rd('h14, v); chk("R1", v, 32'h0);
        rd('h20, v); chk("R1", v, 32'h0);

        // R2: free running count
        cur_req = "R2";
        idle(7);
        rd('h00, v);
        rd('h04, v); chk("R2", v, 32'h0);
        idle(3);
        rd('h00, v);

        // R3 / R8: immediate load near a 32-bit boundary
        cur_req = "R3";
        wr('h08, 32'hFFFF_FFF0);
        wr('h0C, 32'h0000_0001);
        wr('h10, 32'h1);
        rd('h00, v); chk("R3", v, 32'hFFFF_FFF1);
        cur_req = "R8";
        idle(20);
        rd('h04, v); chk("R8", v, 32'h1);
        rd('h00, v);
        rd('h04, v); chk("R8", v, 32'h2);

        // R6 / R7: PPS capture and presence flag
        cur_req = "R6";
        pulse(3, 10);
        rd('h14, v);
        rd('h18, v); chk("R6", v, 32'h2);
        cur_req = "R7";
        pulse(40, 10);
        chk("R7", flip, 1'b0);

        // R4: armed load across two pulses
        cur_req = "R4";
        wr('h08, 32'h9ABC_DEF0);
        wr('h0C, 32'h1234_5678);
        wr('h10, 32'h2);
        idle(12);
        rd('h04, v);
        pulse(2, 8);
        rd('h00, v);
        rd('h04, v); chk("R4", v, 32'h1234_5678);
        pulse(2, 30);
        rd('h14, v);
        rd('h00, v);
        rd('h04, v);

        // R5: immediate load cancels a pending arm
        cur_req = "R5";
        wr('h08, 32'h0000_1000);
        wr('h0C, 32'h0000_0000);
        wr('h10, 32'h2);
        wr('h08, 32'h0000_5000);
        wr('h10, 32'h1);
        pulse(2, 10);
        rd('h00, v);
        rd('h04, v); chk("R5", v, 32'h0);

        // R9: period read-write
        cur_req = "R9";
        wr('h1C, 32'hCAFE_0001);
        wr('h20, 32'h0BAD_F00D);
        rd('h1C, v); chk("R9", v, 32'hCAFE_0001);
        rd('h20, v); chk("R9", v, 32'h0BAD_F00D);

        // R10: ignored writes and zero reads
        cur_req = "R10";
        wr('h00, 32'hFFFF_FFFF);
        wr('h14, 32'hFFFF_FFFF);
        wr('h24, 32'hFFFF_FFFF);
        wr('h10, 32'h3);
        wr('h10, 32'h0);
        rd('h08, v); chk("R10", v, 32'h0);
        rd('h10, v); chk("R10", v, 32'h0);
        rd('h2C, v); chk("R10", v, 32'h0);
        rd('h1C, v); chk("R10", v, 32'hCAFE_0001);
        rd('h14, v);

        // R11: read data holds between reads
        cur_req = "R11";
        rd('h20, v);
        idle(10);
        chk("R11", brdata, 32'h0BAD_F00D);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog(all) actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule